// File: doc/BRIEF.md
# Physical Address Router with SMM Window Protection

This block decides, one request at a time, where a processor-bus access in a 32-bit physical address space must go. Each request carries an address and a qualifier bit telling whether it was issued in system-management mode. The block answers with a one-hot route: ordinary DRAM, the protected SMM window (serviced by DRAM), PCI memory space, interrupt-controller (APIC) space, the firmware region, or master abort.

The low-memory boundary, the top of the SMM window, the window size code and the SMM window enable are held in configuration registers. These registers are loaded through a small write port. The SMM window is not a fixed range. Its base is computed as the window top minus a size chosen by a 2-bit code. Inside an enabled window, only requests carrying the SMM qualifier reach memory, and every other request is aborted. The route decision is registered and appears one clock after the request strobe, marked by a one-cycle valid pulse.

Top module: `addr_route_dec`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge produces `routeValid` high for exactly the following cycle. `routeValid` is low in any cycle that does not follow a sampled request, and it is low after reset.
- R2: Every reported route has exactly one bit set. The route bit positions are: bit0 DRAM, bit1 SMM window, bit2 PCI, bit3 APIC, bit4 firmware, bit5 abort. `masterAbort` is high exactly when bit5 is reported.
- R3: An address below the low-memory top that is in no higher-priority region routes to DRAM. There is no hole at 0x00F0_0000–0x00FF_FFFF, so that range also routes to DRAM.
- R4: Addresses 0xFEC0_0000–0xFEC8_FFFF and 0xFEE0_0000–0xFEEF_FFFF route to APIC. APIC has the highest priority.
- R5: Addresses 0xFF00_0000–0xFFFF_FFFF route to firmware. Only APIC ranks above firmware.
- R6: While the SMM window is enabled, an address with base <= addr < top routes to the SMM window (bit1) if `reqSmm` is high, and to abort (bit5) if `reqSmm` is low. The window ranks below APIC and firmware and above DRAM.
- R7: The window base is top minus a size chosen by the size code: 00 = 512 KB, 01 = 1 MB, 10 = 2 MB, 11 = 4 MB.
- R8: While the SMM window is disabled, an address inside the window follows the normal DRAM/PCI decode, whatever the value of `reqSmm`.
- R9: After reset the low-memory top is 0x8000_0000, the window top equals the low-memory top, the size code is 00 and the window is disabled.
- R10: An address at or above the low-memory top that is in neither the APIC ranges nor the firmware region routes to PCI.
- R11: A configuration write uses `cfgSel` 0 for the low-memory top, 1 for the window top and 2 for control (`cfgData[1:0]` = size code, `cfgData[2]` = enable). The low 19 bits of a written top are forced to zero, so both tops stay 512 KB aligned.
- R12: A configuration write takes effect from the next rising edge. A request sampled at the same edge as a write is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Request physical address |
| reqSmm | input | 1 | Request issued in system-management mode |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Configuration register select |
| cfgData | input | 32 | Configuration write data |
| routeValid | output | 1 | One-cycle pulse marking a new route decision |
| route | output | 6 | One-hot route decision |
| masterAbort | output | 1 | The reported request is aborted |

## Verification
Each route decision is due at the rising edge after the edge that samples the request. The bench raises the strobe at a falling edge and reads `route`, `routeValid` and `masterAbort` at the next falling edge, then reads one more falling edge later to confirm that the valid pulse has ended. A configuration write is likewise applied at a falling edge and counts as settled only after the following rising edge. One scenario places a write and a request at the same edge to show that the request is decoded with the old settings. All region boundaries are probed on both sides of each edge.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
  localparam int ADDR_W  = 32;
  localparam int ROUTE_N = 6;

  // one-hot route bit positions
  localparam int RT_DRAM  = 0;
  localparam int RT_SMM   = 1;
  localparam int RT_PCI   = 2;
  localparam int RT_APIC  = 3;
  localparam int RT_FW    = 4;
  localparam int RT_ABORT = 5;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic              capture;
    logic              smm;
    logic [ADDR_W-1:0] addr;
    logic              smmEn;
    logic [1:0]        sizeCode;
    logic [ADDR_W-1:0] tolm;
    logic [ADDR_W-1:0] tsegTop;
  } ctlToDp_t;
endpackage

// File: rtl/addr_route_ctl.sv
module addr_route_ctl
  import addr_route_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TOLM_RESET = 32'h8000_0000,
  parameter int                ALIGN_BITS = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output ctlToDp_t          strobe
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] tolmReg;
  logic [ADDR_W-1:0] tsegTopReg;
  logic [1:0]        sizeReg;
  logic              smmEnReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tolmReg    <= TOLM_RESET & ALIGN_MASK;
      tsegTopReg <= TOLM_RESET & ALIGN_MASK;
      sizeReg    <= 2'b00;
      smmEnReg   <= 1'b0;
    end else if (cfgWe) begin
      case (cfgSel)
        2'd0: tolmReg    <= cfgData & ALIGN_MASK;
        2'd1: tsegTopReg <= cfgData & ALIGN_MASK;
        2'd2: begin
          sizeReg  <= cfgData[1:0];
          smmEnReg <= cfgData[2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = reqValid;
    strobe.smm      = reqSmm;
    strobe.addr     = reqAddr;
    strobe.smmEn    = smmEnReg;
    strobe.sizeCode = sizeReg;
    strobe.tolm     = tolmReg;
    strobe.tsegTop  = tsegTopReg;
  end

  // R12: window top changes only on a write that selects it
  p_top_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgWe && cfgSel == 2'd1) |=> $stable(tsegTopReg));

  // R11: stored tops keep 512 KB alignment
  p_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWe |=> ((tolmReg | tsegTopReg) & ~ALIGN_MASK) == '0);
endmodule

// File: rtl/addr_route_dp.sv
module addr_route_dp
  import addr_route_pkg::*;
#(
  parameter int                MIN_SHIFT  = 19,
  parameter logic [ADDR_W-1:0] APIC0_LO   = 32'hFEC0_0000,
  parameter logic [ADDR_W-1:0] APIC0_HI   = 32'hFEC8_FFFF,
  parameter logic [ADDR_W-1:0] APIC1_LO   = 32'hFEE0_0000,
  parameter logic [ADDR_W-1:0] APIC1_HI   = 32'hFEEF_FFFF,
  parameter logic [ADDR_W-1:0] FW_BASE    = 32'hFF00_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlToDp_t           strobe,
  output logic               routeValid,
  output logic [ROUTE_N-1:0] route,
  output logic               masterAbort
);
  logic [ADDR_W:0]      sizeBytes;
  logic [ADDR_W:0]      baseWide;
  logic [ADDR_W-1:0]    tsegBase;
  logic                 inApic, inFw, inTseg, inLow;
  logic [ROUTE_N-1:0]   nextRoute;

  always_comb begin
    sizeBytes = (ADDR_W+1)'(1) << (MIN_SHIFT + int'(strobe.sizeCode));
    baseWide  = {1'b0, strobe.tsegTop} - sizeBytes;
    tsegBase  = baseWide[ADDR_W] ? '0 : baseWide[ADDR_W-1:0];

    inApic = (strobe.addr >= APIC0_LO && strobe.addr <= APIC0_HI) ||
             (strobe.addr >= APIC1_LO && strobe.addr <= APIC1_HI);
    inFw   = strobe.addr >= FW_BASE;
    inTseg = strobe.smmEn && strobe.addr >= tsegBase && strobe.addr < strobe.tsegTop;
    inLow  = strobe.addr < strobe.tolm;

    nextRoute = '0;
    if (inApic)           nextRoute[RT_APIC]  = 1'b1;
    else if (inFw)        nextRoute[RT_FW]    = 1'b1;
    else if (inTseg) begin
      if (strobe.smm)     nextRoute[RT_SMM]   = 1'b1;
      else                nextRoute[RT_ABORT] = 1'b1;
    end
    else if (inLow)       nextRoute[RT_DRAM]  = 1'b1;
    else                  nextRoute[RT_PCI]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      routeValid  <= 1'b0;
      route       <= '0;
      masterAbort <= 1'b0;
    end else begin
      routeValid <= strobe.capture;
      if (strobe.capture) begin
        route       <= nextRoute;
        masterAbort <= nextRoute[RT_ABORT];
      end else begin
        masterAbort <= 1'b0;
      end
    end
  end

  // R1: a sampled request yields a valid pulse next cycle
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.capture |=> routeValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> !routeValid);
  // R2: exactly one route bit on every decision
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    routeValid |-> $countones(route) == 1);
  // R6: abort only for a non-SMM request while the window is enabled
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    masterAbort |-> ($past(strobe.smmEn) && !$past(strobe.smm)));
endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec
  import addr_route_pkg::*;
#(
  parameter logic [31:0] TOLM_RESET = 32'h8000_0000,
  parameter int          ALIGN_BITS = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqSmm,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  input  logic [31:0] cfgData,
  output logic        routeValid,
  output logic [5:0]  route,
  output logic        masterAbort
);
  ctlToDp_t strobe;

  addr_route_ctl #(.TOLM_RESET(TOLM_RESET), .ALIGN_BITS(ALIGN_BITS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSmm(reqSmm), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .strobe(strobe)
  );

  addr_route_dp #(.MIN_SHIFT(ALIGN_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .routeValid(routeValid), .route(route), .masterAbort(masterAbort)
  );
endmodule

// File: tb/addr_route_dec_tb.sv
module addr_route_dec_tb;
  localparam logic [5:0] DRAM = 6'b000001, SMM = 6'b000010, PCI = 6'b000100,
                         APIC = 6'b001000, FW  = 6'b010000, ABT = 6'b100000;

  logic clk = 0, rst_n = 0;
  logic reqValid = 0, reqSmm = 0, cfgWe = 0;
  logic [31:0] reqAddr = '0, cfgData = '0;
  logic [1:0] cfgSel = '0;
  logic routeValid, masterAbort;
  logic [5:0] route;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_route_dec u_dut (.clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSmm(reqSmm), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .routeValid(routeValid), .route(route), .masterAbort(masterAbort));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [31:0] data);
    @(negedge clk); cfgWe = 1; cfgSel = sel; cfgData = data;
    @(negedge clk); cfgWe = 0;
  endtask

  // request, check route one edge later, then check the pulse ends
  task automatic probe(string tag, logic [31:0] addr, logic smm, logic [5:0] exp);
    @(negedge clk); reqValid = 1; reqAddr = addr; reqSmm = smm;
    @(negedge clk); reqValid = 0;
    chk({tag, " R1 valid"}, routeValid, 1);
    chk({tag, " route"}, route, exp);
    chk({tag, " R2 abort flag"}, masterAbort, exp == ABT);
    @(negedge clk);
    chk({tag, " R1 pulse end"}, routeValid, 0);
  endtask

  task automatic testReset();
    chk("R1 reset valid", routeValid, 0);
    chk("R1 reset abort", masterAbort, 0);
  endtask

  task automatic testLowMem();
    probe("R3 1MB", 32'h0010_0000, 0, DRAM);
    probe("R3 no hole lo", 32'h00F0_0000, 0, DRAM);
    probe("R3 no hole hi", 32'h00FF_FFFF, 0, DRAM);
    probe("R9 below default top", 32'h7FFF_FFFF, 0, DRAM);
    probe("R10 default top", 32'h8000_0000, 0, PCI);
  endtask

  task automatic testHigh();
    probe("R4 apic0 lo", 32'hFEC0_0000, 0, APIC);
    probe("R4 apic0 hi", 32'hFEC8_FFFF, 0, APIC);
    probe("R10 after apic0", 32'hFEC9_0000, 0, PCI);
    probe("R10 before apic1", 32'hFEDF_FFFF, 0, PCI);
    probe("R4 apic1 lo", 32'hFEE0_0000, 1, APIC);
    probe("R4 apic1 hi", 32'hFEEF_FFFF, 0, APIC);
    probe("R10 below fw", 32'hFEFF_FFFF, 0, PCI);
    probe("R5 fw lo", 32'hFF00_0000, 0, FW);
    probe("R5 fw hi", 32'hFFFF_FFFF, 0, FW);
  endtask

  task automatic testDefaultWindow();
    probe("R8 disabled window", 32'h7FF8_0000, 0, DRAM);
    cfgWrite(2, 32'h4);              // enable, 512 KB
    probe("R9 R6 default window abort", 32'h7FF8_0000, 0, ABT);
    probe("R6 smm access", 32'h7FFF_FFFF, 1, SMM);
    probe("R7 below 512K base", 32'h7FF7_FFFF, 0, DRAM);
  endtask

  task automatic testSizes();
    cfgWrite(1, 32'h4000_0000);
    cfgWrite(2, 32'h5);              // 1 MB
    probe("R7 1MB below", 32'h3FEF_FFFF, 0, DRAM);
    probe("R7 1MB base", 32'h3FF0_0000, 0, ABT);
    probe("R6 at top", 32'h4000_0000, 0, DRAM);
    cfgWrite(2, 32'h6);              // 2 MB
    probe("R7 2MB below", 32'h3FDF_FFFF, 0, DRAM);
    probe("R7 2MB base", 32'h3FE0_0000, 1, SMM);
    cfgWrite(2, 32'h7);              // 4 MB
    probe("R7 4MB below", 32'h3FBF_FFFF, 0, DRAM);
    probe("R7 4MB base", 32'h3FC0_0000, 0, ABT);
  endtask

  task automatic testSameEdge();
    // write size 512 KB in the same cycle as a request at 4 MB base
    @(negedge clk); cfgWe = 1; cfgSel = 2; cfgData = 32'h4;
    reqValid = 1; reqAddr = 32'h3FC0_0000; reqSmm = 0;
    @(negedge clk); cfgWe = 0; reqValid = 0;
    chk("R12 old setting valid", routeValid, 1);
    chk("R12 old setting route", route, ABT);
    @(negedge clk);
    probe("R12 new setting", 32'h3FC0_0000, 0, DRAM);
    cfgWrite(2, 32'h3);              // disable, size 4 MB
    probe("R8 disabled ignores smm", 32'h3FC0_0000, 1, DRAM);
  endtask

  task automatic testTolm();
    cfgWrite(0, 32'h2000_1234);      // aligned down to 0x2000_0000
    probe("R11 tolm aligned", 32'h2000_0000, 0, PCI);
    probe("R11 below tolm", 32'h1FFF_FFFF, 0, DRAM);
    cfgWrite(1, 32'h1008_0ABC);      // top aligned to 0x1008_0000
    cfgWrite(2, 32'h4);
    probe("R11 top aligned in", 32'h1007_FFFF, 0, ABT);
    probe("R11 top aligned out", 32'h1008_0000, 0, DRAM);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    testLowMem();
    testHigh();
    testDefaultWindow();
    testSizes();
    testSameEdge();
    testTolm();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule